// File: doc/BRIEF.md
# Interleaved Banked Block-Read Memory

This block is a word-interleaved memory built from several independent storage banks. A cache-side requester asks for a whole block with one block address. The block's words live in different banks because the lowest bits of each word address pick the bank. A single address phase therefore starts every bank at the same time. Their access latencies overlap, and the words come back over a one-word return bus on back-to-back cycles.

Each bank is modelled as a storage array with a fixed access latency and a down-counter that keeps it busy while an access is in flight. Single-word writes go to one bank and keep only that bank busy. A block read that is accepted while any bank is still busy waits in its address phase until every bank is free. With the default parameters (4 banks, 6-cycle access) a block fill costs 1 + 6 + 4 = 11 cycles. A single bank without interleaving would cost 32.

Top module: `ilv_mem`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block leaves that edge with `rsp_valid` low. Once `rst_n` is high and no bank is busy, `rd_rdy` and `wr_rdy` are high.
- R2: A word address is split into a bank field and a row field. The bank field is its low log2(N_BANKS) bits and the row field is the rest. Word `k` of block `b` is word address `b*N_BANKS + k`, and it is stored in bank `k`.
- R3: Take a block read accepted at edge `a` while all banks are idle. Word `k` is presented (`rsp_valid` high) from edge `a + 1 + ACC_LAT + k` on. The last word's bus cycle ends at edge `a + 1 + ACC_LAT + N_BANKS`, which is 11 cycles with the defaults.
- R4: A block returns as exactly N_BANKS words on consecutive cycles. `rsp_idx` counts 0, 1, ... N_BANKS-1 in order, and `rsp_valid` is low outside the burst.
- R5: `rd_rdy` goes low at the edge that accepts a block read and stays low until the edge that presents the last word. A read request made while `rd_rdy` is low is ignored: it is not queued and produces no burst.
- R6: An access keeps its bank busy for ACC_LAT cycles. `wr_rdy` is high only when no block read is in progress, `rd_req` is low and the bank addressed by `wr_addr` is idle. A bank therefore accepts a new access no earlier than ACC_LAT+1 edges after its previous one.
- R7: A block read accepted while any bank is busy holds its address phase until all banks are idle. Its burst then follows R3, counted from the first edge at which all banks can start.
- R8: When `rd_req` and `wr_req` are both high in an idle cycle, the read is accepted and the write is refused (`wr_rdy` low).
- R9: Each returned word equals the data of the last accepted write to that word address. A refused write has no effect on memory contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_req | input | 1 | Block read request |
| rd_blk | input | ADDR_W-log2(N_BANKS) | Block address of the read |
| rd_rdy | output | 1 | High when a block read can be accepted |
| wr_req | input | 1 | Single-word write request |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Write data |
| wr_rdy | output | 1 | High when the write can be accepted this cycle |
| rsp_valid | output | 1 | A returned word is on `rsp_data` |
| rsp_idx | output | log2(N_BANKS) | Index of the returned word inside its block |
| rsp_data | output | DATA_W | Returned word |

## Verification
The bench targets these corner cases:
- A fill issued on an idle memory must finish in exactly 11 cycles. A design that serialised the bank latencies, or added a cycle to the address phase, would miss that count.
- A fill that follows a write directly must be pushed back until the written bank is free. A design without the busy check would return stale or early data, and would finish in 11 cycles instead of the 16 this case needs.
- Back-to-back writes to one bank must stall `wr_rdy` for the whole access time.
- A read and a write raised together must let only the read through.
- A second read request raised during a burst must leave no trace. A design that queued it would show an extra burst or an early `rd_rdy`.

Each returned word is compared against a shadow copy of memory. This exposes any error in the bank/row split or in the word order.

// File: rtl/ilv_pkg.sv
// Shared definitions for the interleaved banked memory.
// Assumes: nothing beyond the types declared here.
package ilv_pkg;

    // Controller phases of a block read; ST_IDLE also serves single writes.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_WAIT = 2'd2,
        ST_XFER = 2'd3
    } ilv_state_e;

endpackage

// File: rtl/ilv_bank.sv
// One storage bank with a fixed access latency.
// A start pulse begins an access: a write stores wdata at once, a read
// captures the addressed word into rdata. The bank then counts ACC_LAT
// cycles as busy. rdata holds its value until the next read start.
// Assumes: start is never pulsed while busy is high.
module ilv_bank #(
    parameter int DATA_W  = 32,
    parameter int ROW_W   = 4,
    parameter int ACC_LAT = 6,
    localparam int DEPTH  = 1 << ROW_W,
    localparam int CNT_W  = $clog2(ACC_LAT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wen,
    input  logic [ROW_W-1:0]  row,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              last,
    output logic [DATA_W-1:0] rdata
);

    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] mem_q [DEPTH];

    // Busy counter: load on start, count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (start)          cnt_q <= CNT_W'(ACC_LAT);
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    // Storage array write port.
    always_ff @(posedge clk) begin
        if (start && wen) mem_q[row] <= wdata;
    end

    // Read capture register, held until the next read access.
    always_ff @(posedge clk) begin
        if (!rst_n)               rdata <= '0;
        else if (start && !wen)   rdata <= mem_q[row];
    end

    // Status towards the controller.
    always_comb begin
        busy = (cnt_q != '0);
        last = (cnt_q == CNT_W'(1));
    end

endmodule

// File: rtl/ilv_ctrl.sv
// Request controller for the interleaved memory.
// Accepts block reads and single-word writes. It starts every bank at once
// for a block read, after all banks are idle, and returns the words one per
// cycle in ascending order.
// Assumes: all banks started together finish together; a block has
// N_BANKS words, one per bank.
module ilv_ctrl
    import ilv_pkg::*;
#(
    parameter int N_BANKS = 4,
    parameter int DATA_W  = 32,
    parameter int ROW_W   = 4,
    localparam int BSEL_W = $clog2(N_BANKS),
    localparam int ADDR_W = ROW_W + BSEL_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rd_req,
    input  logic [ROW_W-1:0]               rd_blk,
    output logic                           rd_rdy,
    input  logic                           wr_req,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [DATA_W-1:0]              wr_data,
    output logic                           wr_rdy,
    input  logic [N_BANKS-1:0]             bank_busy,
    input  logic [N_BANKS-1:0]             bank_last,
    input  logic [N_BANKS-1:0][DATA_W-1:0] bank_rdata,
    output logic [N_BANKS-1:0]             bank_start,
    output logic                           bank_wen,
    output logic [ROW_W-1:0]               bank_row,
    output logic [DATA_W-1:0]              bank_wdata,
    output logic                           rsp_valid,
    output logic [BSEL_W-1:0]              rsp_idx,
    output logic [DATA_W-1:0]              rsp_data
);

    localparam logic [BSEL_W-1:0] LAST_IDX = BSEL_W'(N_BANKS - 1);

    ilv_state_e        state_q;
    logic [ROW_W-1:0]  blk_q;
    logic [BSEL_W-1:0] word_q;
    logic [BSEL_W-1:0] wr_bank;
    logic [ROW_W-1:0]  wr_row;
    logic              wr_fire;
    logic              rd_fire;
    logic              issue;

    // Address split and handshake decisions.
    always_comb begin
        wr_bank = wr_addr[BSEL_W-1:0];
        wr_row  = wr_addr[ADDR_W-1:BSEL_W];
        rd_rdy  = (state_q == ST_IDLE);
        rd_fire = rd_rdy && rd_req;
        wr_rdy  = (state_q == ST_IDLE) && !rd_req && !bank_busy[wr_bank];
        wr_fire = wr_req && wr_rdy;
        issue   = (state_q == ST_ADDR) && !(|bank_busy);
    end

    // Bank start pulses: all banks for a block read, one bank for a write.
    always_comb begin
        for (int b = 0; b < N_BANKS; b++) begin
            bank_start[b] = issue || (wr_fire && (wr_bank == BSEL_W'(b)));
        end
        bank_wen   = wr_fire;
        bank_row   = issue ? blk_q : wr_row;
        bank_wdata = wr_data;
    end

    // Block read sequencer and return bus register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            blk_q     <= '0;
            word_q    <= '0;
            rsp_valid <= 1'b0;
            rsp_idx   <= '0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (rd_fire) begin
                        blk_q   <= rd_blk;
                        state_q <= ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    if (issue) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (&bank_last) begin
                        rsp_valid <= 1'b1;
                        rsp_idx   <= '0;
                        rsp_data  <= bank_rdata[0];
                        word_q    <= BSEL_W'(1);
                        state_q   <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    rsp_valid <= 1'b1;
                    rsp_idx   <= word_q;
                    rsp_data  <= bank_rdata[word_q];
                    word_q    <= word_q + 1'b1;
                    if (word_q == LAST_IDX) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ilv_mem.sv
// Word-interleaved memory: N_BANKS banks, each ACC_LAT cycles deep.
// The low word-address bits select the bank. A block read starts every
// bank at once and streams the words back in index order.
// Assumes: N_BANKS is a power of two, at least 2.
module ilv_mem #(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 6,
    parameter int N_BANKS = 4,
    parameter int ACC_LAT = 6,
    localparam int BSEL_W = $clog2(N_BANKS),
    localparam int ROW_W  = ADDR_W - BSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ROW_W-1:0]  rd_blk,
    output logic              rd_rdy,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_rdy,
    output logic              rsp_valid,
    output logic [BSEL_W-1:0] rsp_idx,
    output logic [DATA_W-1:0] rsp_data
);

    logic [N_BANKS-1:0]             bank_busy;
    logic [N_BANKS-1:0]             bank_last;
    logic [N_BANKS-1:0][DATA_W-1:0] bank_rdata;
    logic [N_BANKS-1:0]             bank_start;
    logic                           bank_wen;
    logic [ROW_W-1:0]               bank_row;
    logic [DATA_W-1:0]              bank_wdata;

    ilv_ctrl #(
        .N_BANKS (N_BANKS),
        .DATA_W  (DATA_W),
        .ROW_W   (ROW_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_req     (rd_req),
        .rd_blk     (rd_blk),
        .rd_rdy     (rd_rdy),
        .wr_req     (wr_req),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_rdy     (wr_rdy),
        .bank_busy  (bank_busy),
        .bank_last  (bank_last),
        .bank_rdata (bank_rdata),
        .bank_start (bank_start),
        .bank_wen   (bank_wen),
        .bank_row   (bank_row),
        .bank_wdata (bank_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_idx    (rsp_idx),
        .rsp_data   (rsp_data)
    );

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        ilv_bank #(
            .DATA_W  (DATA_W),
            .ROW_W   (ROW_W),
            .ACC_LAT (ACC_LAT)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .start (bank_start[b]),
            .wen   (bank_wen),
            .row   (bank_row),
            .wdata (bank_wdata),
            .busy  (bank_busy[b]),
            .last  (bank_last[b]),
            .rdata (bank_rdata[b])
        );
    end

endmodule

// File: rtl/ilv_mem_chk.sv
// Protocol checker for ilv_mem, attached by bind.
// Watches only the top-level ports of the block.
// Assumes: reset is synchronous and active low.
module ilv_mem_chk #(
    parameter int ADDR_W  = 6,
    parameter int N_BANKS = 4,
    parameter int ACC_LAT = 6,
    localparam int BSEL_W = $clog2(N_BANKS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic              rd_rdy,
    input logic              wr_req,
    input logic              wr_rdy,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              rsp_valid,
    input logic [BSEL_W-1:0] rsp_idx
);

    localparam logic [BSEL_W-1:0] LAST_IDX = BSEL_W'(N_BANKS - 1);

    logic [15:0] since_q;

    // Cycles since the last accepted block read, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_q <= 16'hFFFF;
        else if (rd_req && rd_rdy)  since_q <= '0;
        else if (since_q != 16'hFFFF) since_q <= since_q + 1'b1;
    end

    assert_fill_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> (32'(since_q) >= ACC_LAT + 1));

    assert_first_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> (rsp_idx == '0));

    assert_word_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_idx != LAST_IDX) |=>
            (rsp_valid && rsp_idx == BSEL_W'($past(rsp_idx) + 1'b1)));

    assert_busy_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_rdy) |=> !rd_rdy);

    assert_same_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_req && wr_rdy) && wr_req &&
         wr_addr[BSEL_W-1:0] == $past(wr_addr[BSEL_W-1:0])) |-> !wr_rdy);

    assert_read_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !wr_rdy);

endmodule

bind ilv_mem ilv_mem_chk #(
    .ADDR_W  (ADDR_W),
    .N_BANKS (N_BANKS),
    .ACC_LAT (ACC_LAT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .rd_rdy    (rd_rdy),
    .wr_req    (wr_req),
    .wr_rdy    (wr_rdy),
    .wr_addr   (wr_addr),
    .rsp_valid (rsp_valid),
    .rsp_idx   (rsp_idx)
);

// File: tb/tb_ilv_mem.sv
// Bench for ilv_mem: seeded random traffic plus directed corner cases,
// checked against a shadow memory and a cycle model of bank occupancy.
module tb_ilv_mem;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 6;
    localparam int NB     = 4;
    localparam int ACC    = 6;
    localparam int BSEL_W = 2;
    localparam int ROW_W  = ADDR_W - BSEL_W;
    localparam int NWORDS = 1 << ADDR_W;
    localparam int NBLK   = 1 << ROW_W;

    logic              clk;
    logic              rst_n;
    logic              rd_req;
    logic [ROW_W-1:0]  rd_blk;
    logic              rd_rdy;
    logic              wr_req;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              wr_rdy;
    logic              rsp_valid;
    logic [BSEL_W-1:0] rsp_idx;
    logic [DATA_W-1:0] rsp_data;

    ilv_mem #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .N_BANKS (NB),
        .ACC_LAT (ACC)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .rd_blk    (rd_blk),
        .rd_rdy    (rd_rdy),
        .wr_req    (wr_req),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_rdy    (wr_rdy),
        .rsp_valid (rsp_valid),
        .rsp_idx   (rsp_idx),
        .rsp_data  (rsp_data)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0;
    int bad   = 0;
    logic [DATA_W-1:0] shadow [NWORDS];
    int ok_e [NB];

    task automatic chk(input bit c, input string tag, input longint act, input longint exp);
        total++;
        if (!c) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Earliest edge at which every bank may start again.
    function automatic int all_free();
        int m = 0;
        for (int b = 0; b < NB; b++) if (ok_e[b] > m) m = ok_e[b];
        return m;
    endfunction

    // Single-word write; called and returning just after a falling edge.
    task automatic wr_word(input int addr, input logic [DATA_W-1:0] d);
        int b = addr % NB;
        wr_req  = 1'b1;
        wr_addr = ADDR_W'(addr);
        wr_data = d;
        forever begin
            #1;
            chk(wr_rdy == (cyc + 1 >= ok_e[b]), "R6 wr_rdy", longint'(wr_rdy),
                longint'(cyc + 1 >= ok_e[b]));
            if (wr_rdy) break;
            @(negedge clk);
        end
        ok_e[b]      = cyc + 1 + ACC + 1;
        shadow[addr] = d;
        @(negedge clk);
        wr_req = 1'b0;
    endtask

    // Block read with optional ignored requests during the burst (inject)
    // and an optional write raised together with the read (with_wr).
    task automatic rd_block(input int blk, input bit inject, input bit with_wr,
                            input int wa, output int len);
        int a, s, lst;
        len     = -1;
        rd_req  = 1'b1;
        rd_blk  = ROW_W'(blk);
        if (with_wr) begin
            wr_req  = 1'b1;
            wr_addr = ADDR_W'(wa);
            wr_data = ~shadow[wa];
        end
        #1;
        chk(rd_rdy == 1'b1, "R5 rd_rdy before accept", longint'(rd_rdy), 1);
        if (with_wr) chk(wr_rdy == 1'b0, "R8 write refused", longint'(wr_rdy), 0);
        a   = cyc + 1;
        s   = (a + 1 > all_free()) ? a + 1 : all_free();
        lst = s + ACC + NB - 1;
        forever begin
            @(negedge clk);
            rd_req  = inject && (cyc == a + 2);
            rd_blk  = ROW_W'(blk ^ 1);
            wr_req  = inject && (cyc == a + 3);
            wr_addr = ADDR_W'(blk * NB);
            wr_data = 32'hDEAD_0000;
            #1;
            if (wr_req) chk(wr_rdy == 1'b0, "R6 write during burst", longint'(wr_rdy), 0);
            begin
                bit ev = (cyc >= s + ACC) && (cyc <= lst);
                chk(rsp_valid == ev, "R4 rsp_valid", longint'(rsp_valid), longint'(ev));
                if (ev && rsp_valid) begin
                    int k = cyc - (s + ACC);
                    chk(rsp_idx == BSEL_W'(k), "R4 rsp_idx", longint'(rsp_idx), longint'(k));
                    chk(rsp_data == shadow[blk * NB + k], "R9 rsp_data",
                        longint'(rsp_data), longint'(shadow[blk * NB + k]));
                    if (k == NB - 1) len = cyc + 1 - a;
                end
                chk(rd_rdy == (cyc >= lst), "R5 rd_rdy", longint'(rd_rdy),
                    longint'(cyc >= lst));
            end
            if (cyc >= lst + 2) break;
        end
        rd_req = 1'b0;
        wr_req = 1'b0;
        for (int b = 0; b < NB; b++) ok_e[b] = s + ACC + 1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired act=%0d exp=done", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int len;
        int seed_d;
        seed_d  = $urandom(32'd4242);
        rst_n   = 1'b0;
        rd_req  = 1'b0;
        rd_blk  = '0;
        wr_req  = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        for (int b = 0; b < NB; b++) ok_e[b] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(rsp_valid == 1'b0, "R1 rsp_valid", longint'(rsp_valid), 0);
        chk(rd_rdy == 1'b1, "R1 rd_rdy", longint'(rd_rdy), 1);
        chk(wr_rdy == 1'b1, "R1 wr_rdy", longint'(wr_rdy), 1);
        @(negedge clk);

        // R2: fill every word; consecutive addresses rotate over the banks
        for (int i = 0; i < NWORDS; i++) wr_word(i, $urandom);
        repeat (ACC + 2) @(negedge clk);

        // R3: fill on an idle memory takes 1 + ACC + NB cycles
        rd_block(3, 1'b0, 1'b0, 0, len);
        chk(len == 11, "R3 fill length", longint'(len), 11);

        // R7: read right after a write to bank 2 waits for that bank
        wr_word(2, 32'hA5A5_0002);
        rd_block(5, 1'b0, 1'b0, 0, len);
        chk(len == 16, "R7 stalled fill length", longint'(len), 16);
        rd_block(0, 1'b0, 1'b0, 0, len);

        // R6: back-to-back writes to one bank
        wr_word(8, 32'h1111_0008);
        wr_word(12, 32'h2222_000C);
        wr_word(13, 32'h3333_000D);

        // R8: read and write together, read wins, write leaves memory alone
        rd_block(7, 1'b0, 1'b1, 30, len);
        rd_block(7, 1'b0, 1'b0, 0, len);
        chk(len == 11, "R8 follow-up fill length", longint'(len), 11);

        // R5: extra request mid-burst is ignored
        rd_block(9, 1'b1, 1'b0, 0, len);
        rd_block(2, 1'b0, 1'b0, 0, len);

        // Seeded random traffic
        for (int n = 0; n < 80; n++) begin
            int op = int'($urandom % 3);
            if (op == 0) wr_word(int'($urandom % NWORDS), $urandom);
            else if (op == 1) rd_block(int'($urandom % NBLK), 1'($urandom % 2), 1'b0, 0, len);
            else repeat (int'($urandom % 4)) @(negedge clk);
        end
        for (int bk = 0; bk < NBLK; bk++) rd_block(bk, 1'b0, 1'b0, 0, len);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule